// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Simulation Engine

This block grades test vectors against single stuck-at faults on a small fixed combinational netlist. Every net of the netlist is held as a W-bit word, and each bit position of that word is an independent copy of the circuit. Position 0 is always the fault-free copy. Positions 1 to W-1 each hold a copy with one forced fault. A single pass can therefore grade up to W-1 faults against one vector in one clock.

Software, or a test-generation loop, first fills a slot table. Each table entry names a net, a stuck polarity and a valid flag, and the entry's index is the bit slot it occupies. A start pulse applies a four-bit input vector. One clock later the engine reports, for each slot, whether that faulty copy disagrees with the fault-free copy at either primary output. Detected faults are marked per slot and are no longer injected unless the keep input asks for repeated grading. A counter accumulates how many distinct faults have been found, so that coverage can be read directly.

The netlist has four inputs a, b, c and d, and three gates: e = a AND b, f = c OR d, g = e AND f. The primary outputs are f and g.

Top module: `fsim_engine`

## Requirements
- R1: While reset is asserted and after its release, done is 0, detect is all zero and det_count is 0, and every slot table entry is invalid.
- R2: When start is sampled high at a clock edge, done is high for exactly the following cycle and detect carries the result. In any cycle that does not follow a start, done is 0 and detect is all zero.
- R3: good_out is {g, f} of the fault-free copy for the vector given with start. It is updated together with done.
- R4: vec bit 0 is a, bit 1 is b, bit 2 is c and bit 3 is d. The netlist is e = a&b, f = c|d, g = e&f. Line codes are a=0, b=1, c=2, d=3, e=4, f=5, g=6, and 7 means no line.
- R5: A stuck-at-0 entry (tbl_stuck=0) clears the named line's bit in its slot, and a stuck-at-1 entry (tbl_stuck=1) sets it. The forced value then propagates through the downstream gates of that copy only.
- R6: detect bit k-1 is 1 exactly when slot k's f or g differs from the fault-free f or g, for k = 1 to W-1.
- R7: An entry with tbl_valid=0 or line code 7 injects nothing and never raises its detect bit. A table write to slot 0 has no effect.
- R8: With keep_faults=0, a slot whose fault has been detected is not injected on later starts, and its detect bit stays 0.
- R9: With keep_faults=1, detected faults are still injected and reported on every start.
- R10: det_count increases by one for each slot whose fault is detected for the first time since that slot was last written. It never changes otherwise.
- R11: A write to slot k clears that slot's detected mark. When a write and a start occur in the same cycle, the start is evaluated with the table contents from before the write, and the write's cleared mark wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_slot | input | $clog2(W) | Slot index being written (1 to W-1) |
| tbl_line | input | 3 | Line code of the fault |
| tbl_stuck | input | 1 | Stuck polarity: 0 or 1 |
| tbl_valid | input | 1 | Entry holds a fault |
| keep_faults | input | 1 | 1 suppresses dropping of detected faults |
| start | input | 1 | Evaluate vec this cycle |
| vec | input | 4 | Input vector {d, c, b, a} |
| done | output | 1 | Result valid pulse |
| detect | output | W-1 | Per-slot detection, bit k-1 for slot k |
| good_out | output | 2 | Fault-free {g, f} |
| det_count | output | CNT_W | Count of distinct detected faults |

## Verification
The bench builds the engine with W = 8 and CNT_W = 16. With these values all seven lines fit in one table load, so every stuck-at-0 fault and then every stuck-at-1 fault can be graded against all sixteen input vectors. The same setting brings within reach the dropping sequence across repeated vectors, invalid and no-line entries, writes to the reserved slot, and a write that coincides with a start.

// File: rtl/fsim_pkg.sv
package fsim_pkg;

  localparam int NUM_PI    = 4;
  localparam int NUM_LINES = 7;
  localparam int LINE_W    = 3;

  typedef enum logic [LINE_W-1:0] {
    LN_A    = 3'd0,
    LN_B    = 3'd1,
    LN_C    = 3'd2,
    LN_D    = 3'd3,
    LN_E    = 3'd4,
    LN_F    = 3'd5,
    LN_G    = 3'd6,
    LN_NONE = 3'd7
  } line_e;

  typedef struct packed {
    logic  valid;
    line_e line;
    logic  stuck;
  } fault_ent_t;

endpackage

// File: rtl/fsim_rst_sync.sv
module fsim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/fsim_slot_table.sv
module fsim_slot_table
  import fsim_pkg::*;
#(
  parameter int W = 8,
  localparam int SLOTS  = W - 1,
  localparam int SLOT_W = $clog2(W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SLOT_W-1:0]             wslot,
  input  fault_ent_t                    wentry,
  input  logic                          start,
  input  logic                          keep,
  input  logic [SLOTS-1:0]              hit,
  output logic [SLOTS-1:0]              active,
  output logic [SLOTS-1:0]              seen,
  output logic [NUM_LINES-1:0][W-1:0]   clr_mask,
  output logic [NUM_LINES-1:0][W-1:0]   set_mask
);

  fault_ent_t ent_q [SLOTS];
  logic [SLOTS-1:0] seen_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic       wr_hit;
    logic       ent_en;
    logic       seen_en;
    logic       seen_nxt;

    assign wr_hit = we && (wslot == SLOT_W'(k + 1));

    always_comb begin
      ent_en   = wr_hit;
      seen_en  = wr_hit || (start && hit[k]);
      seen_nxt = wr_hit ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[k] <= '{valid: 1'b0, line: LN_NONE, stuck: 1'b0};
      end else if (ent_en) begin
        ent_q[k] <= wentry;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q[k] <= 1'b0;
      end else if (seen_en) begin
        seen_q[k] <= seen_nxt;
      end
    end

    assign active[k] = ent_q[k].valid && (ent_q[k].line != LN_NONE)
                       && !(seen_q[k] && !keep);
  end

  assign seen = seen_q;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      clr_mask[l] = '0;
      set_mask[l] = '0;
      for (int k = 0; k < SLOTS; k++) begin
        if (active[k] && (ent_q[k].line == line_e'(l))) begin
          if (ent_q[k].stuck) set_mask[l][k+1] = 1'b1;
          else                clr_mask[l][k+1] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fsim_word_eval.sv
module fsim_word_eval
  import fsim_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [NUM_PI-1:0]             vec,
  input  logic [NUM_LINES-1:0][W-1:0]   clr_mask,
  input  logic [NUM_LINES-1:0][W-1:0]   set_mask,
  output logic [W-1:0]                  po_f,
  output logic [W-1:0]                  po_g
);

  logic [NUM_LINES-1:0][W-1:0] net;

  function automatic logic [W-1:0] pin_word(input logic [W-1:0] raw,
                                            input logic [W-1:0] clr,
                                            input logic [W-1:0] set);
    return (raw & ~clr) | set;
  endfunction

  for (genvar i = 0; i < NUM_PI; i++) begin : g_pi
    assign net[i] = pin_word({W{vec[i]}}, clr_mask[i], set_mask[i]);
  end

  assign net[LN_E] = pin_word(net[LN_A] & net[LN_B], clr_mask[LN_E], set_mask[LN_E]);
  assign net[LN_F] = pin_word(net[LN_C] | net[LN_D], clr_mask[LN_F], set_mask[LN_F]);
  assign net[LN_G] = pin_word(net[LN_E] & net[LN_F], clr_mask[LN_G], set_mask[LN_G]);

  assign po_f = net[LN_F];
  assign po_g = net[LN_G];

endmodule

// File: rtl/fsim_slot_cmp.sv
module fsim_slot_cmp #(
  parameter int W = 8,
  localparam int SLOTS = W - 1
) (
  input  logic [W-1:0]     po_f,
  input  logic [W-1:0]     po_g,
  input  logic [SLOTS-1:0] active,
  output logic [SLOTS-1:0] diff
);

  for (genvar k = 1; k < W; k++) begin : g_cmp
    assign diff[k-1] = active[k-1] &&
                       ((po_f[k] ^ po_f[0]) || (po_g[k] ^ po_g[0]));
  end

endmodule

// File: rtl/fsim_engine.sv
module fsim_engine
  import fsim_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 16,
  localparam int SLOTS  = W - 1,
  localparam int SLOT_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [2:0]        tbl_line,
  input  logic              tbl_stuck,
  input  logic              tbl_valid,
  input  logic              keep_faults,
  input  logic              start,
  input  logic [3:0]        vec,
  output logic              done,
  output logic [SLOTS-1:0]  detect,
  output logic [1:0]        good_out,
  output logic [CNT_W-1:0]  det_count
);

  logic                        rst_q_n;
  fault_ent_t                  wentry;
  logic [SLOTS-1:0]            active;
  logic [SLOTS-1:0]            seen;
  logic [SLOTS-1:0]            hit;
  logic [NUM_LINES-1:0][W-1:0] clr_mask;
  logic [NUM_LINES-1:0][W-1:0] set_mask;
  logic [W-1:0]                po_f;
  logic [W-1:0]                po_g;

  logic                        done_nxt;
  logic [SLOTS-1:0]            detect_nxt;
  logic                        good_en;
  logic [1:0]                  good_nxt;
  logic                        cnt_en;
  logic [CNT_W-1:0]            cnt_nxt;
  logic [CNT_W-1:0]            new_hits;

  fsim_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign wentry = '{valid: tbl_valid, line: line_e'(tbl_line), stuck: tbl_stuck};

  fsim_slot_table #(.W(W)) u_table (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .we       (tbl_we),
    .wslot    (tbl_slot),
    .wentry   (wentry),
    .start    (start),
    .keep     (keep_faults),
    .hit      (hit),
    .active   (active),
    .seen     (seen),
    .clr_mask (clr_mask),
    .set_mask (set_mask)
  );

  fsim_word_eval #(.W(W)) u_eval (
    .vec      (vec),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .po_f     (po_f),
    .po_g     (po_g)
  );

  fsim_slot_cmp #(.W(W)) u_cmp (
    .po_f   (po_f),
    .po_g   (po_g),
    .active (active),
    .diff   (hit)
  );

  always_comb begin
    new_hits = '0;
    for (int k = 0; k < SLOTS; k++) begin
      new_hits = new_hits + CNT_W'(hit[k] && !seen[k]);
    end
    done_nxt   = start;
    detect_nxt = start ? hit : '0;
    good_en    = start;
    good_nxt   = {po_g[0], po_f[0]};
    cnt_en     = start;
    cnt_nxt    = det_count + new_hits;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done   <= 1'b0;
      detect <= '0;
    end else begin
      done   <= done_nxt;
      detect <= detect_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      good_out <= '0;
    end else if (good_en) begin
      good_out <= good_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      det_count <= '0;
    end else if (cnt_en) begin
      det_count <= cnt_nxt;
    end
  end

endmodule

// File: rtl/fsim_engine_chk.sv
module fsim_engine_chk #(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [W-2:0]     detect,
  input logic [CNT_W-1:0] det_count
);

  assert_done_after_start_R2: assert property (
    @(posedge clk) disable iff (!rst_n) start |=> done);

  assert_no_spurious_done_R2: assert property (
    @(posedge clk) disable iff (!rst_n) !start |=> !done);

  assert_detect_quiet_R2: assert property (
    @(posedge clk) disable iff (!rst_n) !done |-> (detect == '0));

  assert_count_moves_with_done_R10: assert property (
    @(posedge clk) disable iff (!rst_n) !$stable(det_count) |-> done);

  assert_count_step_bounded_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
      done |-> ((det_count - $past(det_count)) <= CNT_W'($countones(detect))));

endmodule

bind fsim_engine fsim_engine_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .start     (start),
  .done      (done),
  .detect    (detect),
  .det_count (det_count)
);

// File: tb/test_fsim_engine.sv
module test_fsim_engine;

  localparam int CLK_PERIOD = 10;
  localparam int W      = 8;
  localparam int CNT_W  = 16;
  localparam int SLOTS  = W - 1;
  localparam int SLOT_W = $clog2(W);

  logic              clk;
  logic              rst_n;
  logic              tbl_we;
  logic [SLOT_W-1:0] tbl_slot;
  logic [2:0]        tbl_line;
  logic              tbl_stuck;
  logic              tbl_valid;
  logic              keep_faults;
  logic              start;
  logic [3:0]        vec;
  logic              done;
  logic [SLOTS-1:0]  detect;
  logic [1:0]        good_out;
  logic [CNT_W-1:0]  det_count;

  int n_run;
  int n_fail;
  bit finished;

  logic b_valid [1:SLOTS];
  int   b_line  [1:SLOTS];
  logic b_sv    [1:SLOTS];
  logic b_seen  [1:SLOTS];
  int   b_count;

  fsim_engine #(.W(W), .CNT_W(CNT_W)) i_fsim_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbl_we      (tbl_we),
    .tbl_slot    (tbl_slot),
    .tbl_line    (tbl_line),
    .tbl_stuck   (tbl_stuck),
    .tbl_valid   (tbl_valid),
    .keep_faults (keep_faults),
    .start       (start),
    .vec         (vec),
    .done        (done),
    .detect      (detect),
    .good_out    (good_out),
    .det_count   (det_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Circuit model with an optional single stuck-at fault (ln = -1: none)
  function automatic logic [1:0] model(input logic [3:0] v, input int ln, input logic sv);
    logic a, b, c, d, e, f, g;
    a = v[0]; if (ln == 0) a = sv;
    b = v[1]; if (ln == 1) b = sv;
    c = v[2]; if (ln == 2) c = sv;
    d = v[3]; if (ln == 3) d = sv;
    e = a & b; if (ln == 4) e = sv;
    f = c | d; if (ln == 5) f = sv;
    g = e & f; if (ln == 6) g = sv;
    return {g, f};
  endfunction

  function automatic logic [SLOTS-1:0] expect_det(input logic [3:0] v, input logic kp);
    logic [SLOTS-1:0] r;
    r = '0;
    for (int k = 1; k <= SLOTS; k++) begin
      if (b_valid[k] && b_line[k] != 7 && !(b_seen[k] && !kp))
        r[k-1] = (model(v, b_line[k], b_sv[k]) != model(v, -1, 1'b0));
    end
    return r;
  endfunction

  task automatic load(input int slot, input logic val, input int ln, input logic sv);
    @(negedge clk);
    chk("R2 done idle", 32'(done), 32'd0);
    tbl_we = 1'b1; tbl_slot = SLOT_W'(slot); tbl_line = 3'(ln);
    tbl_stuck = sv; tbl_valid = val;
    if (slot >= 1) begin
      b_valid[slot] = val; b_line[slot] = ln; b_sv[slot] = sv; b_seen[slot] = 1'b0;
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // start, optionally with a coincident write to wslot
  task automatic go(input logic [3:0] v, input logic kp, input string req,
                    input int wslot);
    logic [SLOTS-1:0] ed;
    logic [1:0] eg;
    @(negedge clk);
    chk("R2 done single cycle", 32'(done), 32'd0);
    ed = expect_det(v, kp);
    eg = model(v, -1, 1'b0);
    start = 1'b1; vec = v; keep_faults = kp;
    if (wslot >= 1) begin
      tbl_we = 1'b1; tbl_slot = SLOT_W'(wslot); tbl_line = 3'd6;
      tbl_stuck = 1'b1; tbl_valid = 1'b1;
    end
    for (int k = 1; k <= SLOTS; k++) begin
      if (ed[k-1] && !b_seen[k]) begin
        b_count++; b_seen[k] = 1'b1;
      end
    end
    if (wslot >= 1) begin
      b_valid[wslot] = 1'b1; b_line[wslot] = 6; b_sv[wslot] = 1'b1; b_seen[wslot] = 1'b0;
    end
    @(negedge clk);
    start = 1'b0; tbl_we = 1'b0;
    chk("R2 done", 32'(done), 32'd1);
    chk(req, 32'(detect), 32'(ed));
    chk("R3 good outputs", 32'(good_out), 32'(eg));
    chk("R10 count", 32'(det_count), 32'(b_count));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; finished = 0; b_count = 0;
    for (int k = 1; k <= SLOTS; k++) begin
      b_valid[k] = 0; b_line[k] = 7; b_sv[k] = 0; b_seen[k] = 0;
    end
    rst_n = 1'b0; tbl_we = 0; tbl_slot = '0; tbl_line = '0; tbl_stuck = 0;
    tbl_valid = 0; keep_faults = 0; start = 0; vec = '0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 detect in reset", 32'(detect), 32'd0);
    chk("R1 count in reset", 32'(det_count), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 count after reset", 32'(det_count), 32'd0);

    // R1: empty table injects nothing
    for (int v = 0; v < 16; v++) go(4'(v), 1'b1, "R1 empty table detect", 0);

    // R4 R5 R6 R9: every stuck-at-0, kept, all vectors
    for (int k = 1; k <= SLOTS; k++) load(k, 1'b1, k - 1, 1'b0);
    for (int v = 0; v < 16; v++) go(4'(v), 1'b1, "R5 R6 R9 sa0 detect", 0);

    // R4 R5 R6 R9: every stuck-at-1, kept, all vectors
    for (int k = 1; k <= SLOTS; k++) load(k, 1'b1, k - 1, 1'b1);
    for (int v = 15; v >= 0; v--) go(4'(v), 1'b1, "R5 R6 R9 sa1 detect", 0);

    // R8: dropping, stuck-at-0 set, vectors repeated twice
    for (int k = 1; k <= SLOTS; k++) load(k, 1'b1, k - 1, 1'b0);
    for (int r = 0; r < 2; r++)
      for (int v = 15; v >= 0; v--) go(4'(v), 1'b0, "R8 dropped detect", 0);

    // R7: invalid entry, no-line entry, slot 0 write ignored
    load(1, 1'b0, 0, 1'b1);
    load(2, 1'b1, 7, 1'b0);
    load(3, 1'b1, 6, 1'b1);
    load(0, 1'b1, 5, 1'b0);
    for (int k = 4; k <= SLOTS; k++) load(k, 1'b0, 0, 1'b0);
    for (int v = 0; v < 16; v++) go(4'(v), 1'b1, "R7 invalid entries", 0);

    // R11: write coinciding with start; old contents evaluated, mark cleared
    load(4, 1'b1, 5, 1'b0);
    go(4'b0100, 1'b0, "R11 write with start old entry", 4);
    go(4'b0000, 1'b0, "R11 rewritten slot injects again", 0);
    go(4'b0000, 1'b0, "R8 R11 dropped after redetect", 0);

    @(negedge clk);
    chk("R2 done after last", 32'(done), 32'd0);
    chk("R2 detect after last", 32'(detect), 32'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule